// File: doc/BRIEF.md
# Digital Pin Controller with Edge Interrupts, Wake and Sleep Freeze

This block controls a set of digital pads through a small register interface. For each pin, software sets an output value, an output enable, a drive mode (push-pull or open-drain), pull-up and pull-down requests, the edge that triggers an interrupt, an interrupt enable and a wake enable. The pad inputs pass through a two-flop synchroniser. Selected edges set sticky flags. The flags drive one combined interrupt line and a wake request.

A power controller can assert a freeze input before sleep. While freeze is high, the pad outputs, output enables and pulls keep the values they had, and register writes wait until freeze drops before they reach the pads. Pins marked as shutdown-wake sources compare the raw pad level with the level captured on entry to freeze. Any difference raises the wake request through combinational logic only, so the request forms even when no clock is running.

Top module: `pin_ctrl`

## Requirements
- R1: After reset, every configuration register and every flag reads 0, and pad_out, pad_oe, pad_pu, pad_pd, irq and wake_req are all 0.
- R2: Register addresses are: 0 output value, 1 output enable, 2 open-drain select, 3 pull-up, 4 pull-down, 5 edge select, 6 interrupt enable, 7 wake enable, 8 shutdown-wake select, 9 flags, 10 synchronised pad input (read only). Any other address reads 0. A written register reads back its value on the next cycle.
- R3: With open-drain select 0 (push-pull), pad_out equals the output value and pad_oe equals the output enable. Both take effect at the clock edge that performs the write.
- R4: With open-drain select 1, pad_out is 0 and pad_oe is the output enable AND the inverse of the output value.
- R5: pad_pu follows the pull-up register. pad_pd follows the pull-down register except where pull-up is also 1; there pad_pd is 0.
- R6: With edge select 1, a 0-to-1 change on a pad input sets that pin's flag at the third rising clock edge after the change. A 1-to-0 change sets nothing.
- R7: With edge select 0, a 1-to-0 change on a pad input sets that pin's flag with the same timing. A 0-to-1 change sets nothing.
- R8: Flags are sticky. Writing to address 9 clears exactly the bits written as 1 and leaves every other flag unchanged.
- R9: irq is the OR over pins of flag AND interrupt enable.
- R10: wake_req is 1 when any pin has both its flag and its wake enable set.
- R11: While freeze is high, pad_out, pad_oe, pad_pu and pad_pd hold. Writes still update the registers, and the pads take the new values at the first clock edge after freeze drops.
- R12: While freeze is high, a pin with both wake enable and shutdown-wake select set drives wake_req high, with no clock edge needed, whenever its raw pad level differs from the level it had on entry to freeze. This holds in either direction, whatever the edge select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 4 | Read address |
| rd_data | output | NPINS | Read data, combinational from rd_addr |
| freeze | input | 1 | Hold pad controls from the power controller |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pull-up controls |
| pad_pd | output | NPINS | Pull-down controls |
| irq | output | 1 | Combined interrupt |
| wake_req | output | 1 | Wake request |

## Verification
The assertions assume that the write bus and freeze change only between clock edges. They also assume that pad_in stays constant through reset and changes at most once every few cycles, so each edge travels through the synchroniser alone. The bench changes every input on the falling clock edge and holds each pad level for at least four cycles, except in the freeze test. That test changes a pad and restores it inside one low clock phase, so no rising edge samples the change and only the combinational wake path can respond.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    A_DOUT   = 4'd0,
    A_OE     = 4'd1,
    A_OD     = 4'd2,
    A_PU     = 4'd3,
    A_PD     = 4'd4,
    A_EDGE   = 4'd5,
    A_IRQEN  = 4'd6,
    A_WAKEEN = 4'd7,
    A_SDWAKE = 4'd8,
    A_FLAGS  = 4'd9,
    A_PIN    = 4'd10
  } reg_addr_e;

  // drive value seen by the pad
  function automatic logic f_pad_out(input logic dout, input logic od);
    return od ? 1'b0 : dout;
  endfunction

  // open-drain releases on 1, drives low on 0
  function automatic logic f_pad_oe(input logic dout, input logic oe, input logic od);
    return oe & (od ? ~dout : 1'b1);
  endfunction

  // pull-up wins when both pulls requested
  function automatic logic f_pad_pd(input logic pu, input logic pd);
    return pd & ~pu;
  endfunction
endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] edge_sel,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] evt_o
);
  logic [NPINS-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pad_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_evt
    logic rise_w, fall_w;
    assign rise_w   = s2_q[i] & ~prev_q[i];
    assign fall_w   = ~s2_q[i] & prev_q[i];
    assign evt_o[i] = edge_sel[i] ? rise_w : fall_w;
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/pin_pad_hold.sv
module pin_pad_hold #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [NPINS-1:0] dout_nx,
  input  logic [NPINS-1:0] oe_nx,
  input  logic [NPINS-1:0] od_nx,
  input  logic [NPINS-1:0] pu_nx,
  input  logic [NPINS-1:0] pd_nx,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd
);
  import pin_ctrl_pkg::*;

  logic [NPINS-1:0] out_w, oe_w, pd_w;

  for (genvar i = 0; i < NPINS; i++) begin : g_drv
    assign out_w[i] = f_pad_out(dout_nx[i], od_nx[i]);
    assign oe_w[i]  = f_pad_oe(dout_nx[i], oe_nx[i], od_nx[i]);
    assign pd_w[i]  = f_pad_pd(pu_nx[i], pd_nx[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
    end else if (!freeze) begin
      pad_out <= out_w;
      pad_oe  <= oe_w;
      pad_pu  <= pu_nx;
      pad_pd  <= pd_w;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze)) |-> ($stable(pad_out) && $stable(pad_oe)
                                   && $stable(pad_pu) && $stable(pad_pd)));

  p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);
endmodule

// File: rtl/pin_ctrl.sv
module pin_ctrl #(
  parameter int unsigned NPINS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [pin_ctrl_pkg::AW-1:0]  wr_addr,
  input  logic [NPINS-1:0]             wr_data,
  input  logic [pin_ctrl_pkg::AW-1:0]  rd_addr,
  output logic [NPINS-1:0]             rd_data,
  input  logic                         freeze,
  input  logic [NPINS-1:0]             pad_in,
  output logic [NPINS-1:0]             pad_out,
  output logic [NPINS-1:0]             pad_oe,
  output logic [NPINS-1:0]             pad_pu,
  output logic [NPINS-1:0]             pad_pd,
  output logic                         irq,
  output logic                         wake_req
);
  import pin_ctrl_pkg::*;

  localparam int unsigned NCFG = 9;

  // configuration registers, indexed by address 0..NCFG-1
  logic [NPINS-1:0] cfg_q  [NCFG];
  logic [NPINS-1:0] cfg_nx [NCFG];
  logic [NPINS-1:0] flags_q, clr_mask, evt_w, sync_w, ref_q, lvl_chg;

  for (genvar a = 0; a < NCFG; a++) begin : g_cfg
    assign cfg_nx[a] = (wr_en && wr_addr == AW'(a)) ? wr_data : cfg_q[a];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[a] <= '0;
      else        cfg_q[a] <= cfg_nx[a];
    end
  end

  pin_edge_det #(.NPINS(NPINS)) i_edge (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .edge_sel(cfg_q[A_EDGE]),
    .sync_o(sync_w), .evt_o(evt_w)
  );

  pin_pad_hold #(.NPINS(NPINS)) i_hold (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .dout_nx(cfg_nx[A_DOUT]), .oe_nx(cfg_nx[A_OE]), .od_nx(cfg_nx[A_OD]),
    .pu_nx(cfg_nx[A_PU]), .pd_nx(cfg_nx[A_PD]),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  assign clr_mask = (wr_en && wr_addr == A_FLAGS) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ref_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | evt_w;
      if (!freeze) ref_q <= sync_w;
    end
  end

  // clock-free level-change path for shutdown-wake pins
  assign lvl_chg  = {NPINS{freeze}} & (pad_in ^ ref_q);
  assign irq      = |(flags_q & cfg_q[A_IRQEN]);
  assign wake_req = |(flags_q & cfg_q[A_WAKEEN])
                  | |(lvl_chg & cfg_q[A_WAKEEN] & cfg_q[A_SDWAKE]);

  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NCFG))       rd_data = cfg_q[rd_addr];
    else if (rd_addr == A_FLAGS)   rd_data = flags_q;
    else if (rd_addr == A_PIN)     rd_data = sync_w;
  end

  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_w) |=> ((flags_q & $past(evt_w)) == $past(evt_w)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags_q) & ~flags_q & ~$past(clr_mask)) == '0));
endmodule

// File: tb/test_pin_ctrl.sv
module test_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, freeze = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] wr_data = '0, pad_in = '0;
  logic [N-1:0] rd_data, pad_out, pad_oe, pad_pu, pad_pd;
  logic irq, wake_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_ctrl #(.NPINS(N)) i_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .freeze(freeze), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .irq(irq), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [N-1:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 pad_out", pad_out, 0); chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_pu", pad_pu, 0);   chk("R1 pad_pd", pad_pd, 0);
    chk("R1 irq", irq, 0);         chk("R1 wake", wake_req, 0);
    for (int a = 0; a < 10; a++) rd_chk("R1 reg", 4'(a), 0);
  endtask

  task automatic t_regs;
    wr(4'd6, 8'hA5);
    rd_chk("R2 readback irq_en", 4'd6, 8'hA5);
    rd_chk("R2 unmapped", 4'd13, 0);
    wr(4'd6, 8'h00);
  endtask

  task automatic t_push_pull;
    wr(4'd0, 8'h3C); wr(4'd1, 8'h0F);
    chk("R3 pad_out", pad_out, 8'h3C);
    chk("R3 pad_oe", pad_oe, 8'h0F);
  endtask

  task automatic t_open_drain;
    wr(4'd2, 8'hFF);
    chk("R4 pad_out low", pad_out, 8'h00);
    chk("R4 pad_oe", pad_oe, 8'h0F & ~8'h3C);
    wr(4'd2, 8'h00);
  endtask

  task automatic t_pulls;
    wr(4'd3, 8'h0F); wr(4'd4, 8'h33);
    chk("R5 pad_pu", pad_pu, 8'h0F);
    chk("R5 pad_pd priority", pad_pd, 8'h30);
  endtask

  task automatic t_rise;
    wr(4'd5, 8'h01);
    @(negedge clk); pad_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R6 not yet", 4'd9, 0);
    @(negedge clk);
    rd_chk("R6 rise flag", 4'd9, 8'h01);
    wr(4'd9, 8'h01);
    pad_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R6 fall ignored", 4'd9, 0);
  endtask

  task automatic t_fall;
    @(negedge clk); pad_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R7 rise ignored", 4'd9, 0);
    pad_in[1] = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R7 fall flag", 4'd9, 8'h02);
  endtask

  task automatic t_sticky_irq;
    pad_in[4] = 1'b1; repeat (4) @(negedge clk);
    pad_in[4] = 1'b0; repeat (4) @(negedge clk);
    rd_chk("R8 sticky", 4'd9, 8'h12);
    chk("R9 irq off", irq, 0);
    wr(4'd6, 8'h10);
    chk("R9 irq on", irq, 1);
    wr(4'd9, 8'h02);
    rd_chk("R8 partial clear", 4'd9, 8'h10);
    wr(4'd9, 8'h10);
    chk("R9 irq cleared", irq, 0);
  endtask

  task automatic t_wake_edge;
    wr(4'd5, 8'h20); wr(4'd7, 8'h20);
    @(negedge clk); pad_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 wake set", wake_req, 1);
    wr(4'd9, 8'h20);
    chk("R10 wake cleared", wake_req, 0);
    pad_in[5] = 1'b0; repeat (4) @(negedge clk);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_freeze;
    wr(4'd0, 8'h0F); wr(4'd1, 8'hFF);
    @(negedge clk); freeze = 1'b1;
    wr(4'd0, 8'hF0); wr(4'd3, 8'h00);
    chk("R11 out held", pad_out, 8'h0F);
    chk("R11 pu held", pad_pu, 8'h0F);
    rd_chk("R11 reg updated", 4'd0, 8'hF0);
    freeze = 1'b0; #1;
    chk("R11 before edge", pad_out, 8'h0F);
    @(negedge clk);
    chk("R11 released", pad_out, 8'hF0);
    chk("R11 pu released", pad_pu, 8'h00);
  endtask

  task automatic t_sd_wake;
    wr(4'd5, 8'h00);
    pad_in[3] = 1'b1; repeat (4) @(negedge clk);
    wr(4'd9, 8'hFF);
    wr(4'd7, 8'h0C); wr(4'd8, 8'h0C);
    @(negedge clk); freeze = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 idle", wake_req, 0);
    #1 pad_in[2] = 1'b1; #1;
    chk("R12 rise wake", wake_req, 1);
    #1 pad_in[2] = 1'b0; #1;
    chk("R12 back", wake_req, 0);
    @(negedge clk);
    #1 pad_in[3] = 1'b0; #1;
    chk("R12 fall wake", wake_req, 1);
    #1 pad_in[3] = 1'b1;
    @(negedge clk); freeze = 1'b0;
    @(negedge clk);
    chk("R12 off after freeze", wake_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs(); t_push_pull(); t_open_drain(); t_pulls();
    t_rise(); t_fall(); t_sticky_irq(); t_wake_edge();
    t_freeze(); t_sd_wake();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule